// File: doc/BRIEF.md
# SPI Bus Monitor

This block listens to a four-wire SPI bus without driving any of its lines. It runs on a fast system clock and brings the bus clock, both data lines and the chip-select line into that domain. It then finds the bus clock edges and assembles the serial traffic into words. The master-to-slave and slave-to-master lines are shifted in together, each into its own register. Every finished word is reported with a single strobe that carries both data words.

The monitor also tracks the chip-select line. It reports every change of that line with the old and new pin levels, and it marks the start and end of each transfer. When a transfer ends, it gives the number of words seen in that transfer. Clock polarity, clock phase, chip-select polarity, bit order, word length and the presence of each line are set at run time through a single write strobe. A write is accepted only while the bus is idle.

Top module: `spi_bus_monitor`

## Requirements
- R1: After reset every output is 0. The configuration resets to: clock polarity 0, clock phase 0, chip-select active low, MSB first, word length 8, both data lines present, chip-select framing on.
- R2: The capture edge depends on the (polarity, phase) pair. Pairs (0,0) and (1,1) capture on the rising bus clock edge. Pairs (0,1) and (1,0) capture on the falling edge.
- R3: With MSB first, the k-th captured bit (k counted from 0) goes to word position len-1-k. With LSB first, it goes to position k. Positions at and above len read 0.
- R4: A word is reported when len bits have been captured, and the bit count then restarts. len may be 1 to MAX_WORD. A configuration write with len 0, with len above MAX_WORD, or with both data lines absent is ignored.
- R5: With csActiveHigh=1 the chip-select line is asserted when the pin is high. Otherwise it is asserted when the pin is low.
- R6: With framing on, any change of the chip-select pin discards the partial word and clears the bit count.
- R7: With framing on, bus clock edges are ignored while chip-select is deasserted.
- R8: With framing on, each pin change gives a one-cycle csEvent with csOld and csNew. An assertion also gives xferStart. A deassertion also gives xferEnd, with xferWords equal to the number of words reported since the matching xferStart.
- R9: frameWarn pulses together with wordValid when the chip-select line was not asserted at the moment the word's first bit was captured.
- R10: An absent data line has its word output held at 0 and its valid flag low. wordValid still pulses for every word.
- R11: A configuration write is applied only while framing is off or chip-select is deasserted. Otherwise it is ignored. An applied write restarts the bit count.
- R12: A word, its warning and a chip-select event appear in the cycle after the third system clock edge that follows the bus pin change causing them.
- R13: With framing off, every capture edge is taken whatever the chip-select level, and no csEvent, xferStart or xferEnd is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sckIn | input | 1 | Bus clock pin |
| mosiIn | input | 1 | Master-to-slave data pin |
| misoIn | input | 1 | Slave-to-master data pin |
| csIn | input | 1 | Chip-select pin |
| cfgWrite | input | 1 | Configuration write strobe |
| cfgCpol | input | 1 | Clock polarity |
| cfgCpha | input | 1 | Clock phase |
| cfgCsActiveHigh | input | 1 | Chip-select polarity, 1 = active high |
| cfgLsbFirst | input | 1 | Bit order, 1 = LSB first |
| cfgWordLen | input | LEN_W | Word length in bits |
| cfgMosiEn | input | 1 | Master-to-slave line present |
| cfgMisoEn | input | 1 | Slave-to-master line present |
| cfgCsEn | input | 1 | Chip-select framing on |
| wordValid | output | 1 | Word finished strobe |
| mosiValid | output | 1 | Master-to-slave word valid |
| misoValid | output | 1 | Slave-to-master word valid |
| mosiWord | output | MAX_WORD | Master-to-slave word |
| misoWord | output | MAX_WORD | Slave-to-master word |
| frameWarn | output | 1 | Word started without chip-select |
| csEvent | output | 1 | Chip-select pin changed |
| csOld | output | 1 | Pin level before the change |
| csNew | output | 1 | Pin level after the change |
| xferStart | output | 1 | Transfer start |
| xferEnd | output | 1 | Transfer end |
| xferWords | output | CNT_W | Words in the transfer just ended |

## Verification
Every result appears three system clock edges after the pin change that causes it. Two of those edges are the synchroniser and the third is the output register, so a word shows up after the edges of its last capture, and start and end marks after the chip-select change. A directed case drives one capture edge and samples wordValid on the falling clock edge after the second and after the third rising edge, expecting 0 and then 1. All other checks wait out that latency with idle margin before reading the values the monitor has gathered from the outputs at falling edges. Random configurations and data are checked against words the bench rebuilds from the bits it drove.

// File: rtl/spi_mon_pkg.sv
package spi_mon_pkg;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic csHigh;
    logic lsbFirst;
    logic mosiEn;
    logic misoEn;
    logic csEn;
  } monCfg_t;

  typedef struct packed {
    logic clear;  // drop partial word
    logic take;   // capture one bit on each line
    logic last;   // this capture finishes the word
  } monStrobe_t;

  localparam monCfg_t CFG_RESET = '{cpol: 1'b0, cpha: 1'b0, csHigh: 1'b0,
                                    lsbFirst: 1'b0, mosiEn: 1'b1,
                                    misoEn: 1'b1, csEn: 1'b1};

endpackage

// File: rtl/spi_mon_sync.sv
module spi_mon_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < STAGES; k++) pipe[k] <= RST_VAL;
    end else begin
      pipe[0] <= din;
      for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/spi_mon_ctrl.sv
module spi_mon_ctrl
  import spi_mon_pkg::*;
#(
  parameter int MAX_WORD = 32,
  parameter int DEF_LEN = 8,
  parameter int LEN_W = 6,
  parameter int IDX_W = 5,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sckS,
  input  logic             csS,
  input  logic             cfgWrite,
  input  monCfg_t          cfgIn,
  input  logic [LEN_W-1:0] cfgLen,
  output monStrobe_t       stb,
  output logic [IDX_W-1:0] bitPos,
  output logic [1:0]       chanEn,
  output logic             frameWarn,
  output logic             csEvent,
  output logic             csOld,
  output logic             csNew,
  output logic             xferStart,
  output logic             xferEnd,
  output logic [CNT_W-1:0] xferWords
);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_WORD);
  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  monCfg_t          cfgQ;
  logic [LEN_W-1:0] lenQ;
  logic [LEN_W-1:0] bitCnt;
  logic [CNT_W-1:0] xferCnt;
  logic             sckPrev, csPrev, warnArm;

  logic csAsserted, sampleEdge, csChange, cfgAccept, idle, wordDone, warnNow;

  always_comb begin
    csAsserted = cfgQ.csHigh ? csS : !csS;
    // rising capture when cpol == cpha, falling otherwise
    sampleEdge = (sckS != sckPrev) && (sckS == !(cfgQ.cpol ^ cfgQ.cpha));
    csChange   = cfgQ.csEn && (csS != csPrev);
    idle       = !cfgQ.csEn || !csAsserted;
    cfgAccept  = cfgWrite && idle && (cfgIn.mosiEn || cfgIn.misoEn) &&
                 (cfgLen != '0) && (cfgLen <= LEN_MAX);
    stb.clear  = csChange || cfgAccept;
    stb.take   = sampleEdge && (!cfgQ.csEn || csAsserted) && !stb.clear;
    wordDone   = (bitCnt == lenQ - LEN_W'(1));
    stb.last   = stb.take && wordDone;
    bitPos     = cfgQ.lsbFirst ? bitCnt[IDX_W-1:0]
                               : IDX_W'(lenQ - LEN_W'(1) - bitCnt);
    chanEn     = {cfgQ.misoEn, cfgQ.mosiEn};
    warnNow    = (bitCnt == '0) ? !csAsserted : warnArm;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ      <= CFG_RESET;
      lenQ      <= LEN_W'(DEF_LEN);
      bitCnt    <= '0;
      xferCnt   <= '0;
      sckPrev   <= 1'b1;
      csPrev    <= 1'b1;
      warnArm   <= 1'b0;
      frameWarn <= 1'b0;
      csEvent   <= 1'b0;
      csOld     <= 1'b0;
      csNew     <= 1'b0;
      xferStart <= 1'b0;
      xferEnd   <= 1'b0;
      xferWords <= '0;
    end else begin
      sckPrev <= sckS;
      csPrev  <= csS;
      if (cfgAccept) begin
        cfgQ <= cfgIn;
        lenQ <= cfgLen;
      end
      if (stb.clear) bitCnt <= '0;
      else if (stb.take) bitCnt <= wordDone ? '0 : bitCnt + LEN_W'(1);
      if (stb.take && bitCnt == '0) warnArm <= !csAsserted;
      frameWarn <= stb.last && warnNow;
      csEvent   <= csChange;
      xferStart <= csChange && csAsserted;
      xferEnd   <= csChange && !csAsserted;
      if (csChange) begin
        csOld <= csPrev;
        csNew <= csS;
      end
      if (csChange && csAsserted) xferCnt <= '0;
      else if (stb.last && cfgQ.csEn && xferCnt != CNT_SAT) xferCnt <= xferCnt + CNT_W'(1);
      if (csChange && !csAsserted) xferWords <= xferCnt;
    end
  end
endmodule

// File: rtl/spi_mon_datapath.sv
module spi_mon_datapath
  import spi_mon_pkg::*;
#(
  parameter int MAX_WORD = 32,
  parameter int IDX_W = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  monStrobe_t          stb,
  input  logic [IDX_W-1:0]    bitPos,
  input  logic [1:0]          chanEn,
  input  logic                mosiBit,
  input  logic                misoBit,
  output logic                wordValid,
  output logic                mosiValid,
  output logic                misoValid,
  output logic [MAX_WORD-1:0] mosiWord,
  output logic [MAX_WORD-1:0] misoWord
);
  localparam int NCH = 2;

  logic [NCH-1:0]               bitIn;
  logic [NCH-1:0]               chValid;
  logic [NCH-1:0][MAX_WORD-1:0] wordOut;

  assign bitIn = {misoBit, mosiBit};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    logic [MAX_WORD-1:0] acc, wordQ, nxt;
    assign nxt = acc | (MAX_WORD'(bitIn[ch]) << bitPos);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        acc         <= '0;
        wordQ       <= '0;
        chValid[ch] <= 1'b0;
      end else begin
        chValid[ch] <= stb.last && chanEn[ch];
        if (stb.clear) acc <= '0;
        else if (stb.take) begin
          if (stb.last) begin
            acc   <= '0;
            wordQ <= nxt;
          end else begin
            acc <= nxt;
          end
        end
      end
    end
    assign wordOut[ch] = chanEn[ch] ? wordQ : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wordValid <= 1'b0;
    else       wordValid <= stb.last;
  end

  assign mosiValid = chValid[0];
  assign misoValid = chValid[1];
  assign mosiWord  = wordOut[0];
  assign misoWord  = wordOut[1];
endmodule

// File: rtl/spi_bus_monitor.sv
module spi_bus_monitor
  import spi_mon_pkg::*;
#(
  parameter int MAX_WORD = 32,
  parameter int DEF_LEN = 8,
  parameter int CNT_W = 16,
  parameter int SYNC_STAGES = 2,
  localparam int LEN_W = $clog2(MAX_WORD + 1),
  localparam int IDX_W = $clog2(MAX_WORD)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sckIn,
  input  logic                mosiIn,
  input  logic                misoIn,
  input  logic                csIn,
  input  logic                cfgWrite,
  input  logic                cfgCpol,
  input  logic                cfgCpha,
  input  logic                cfgCsActiveHigh,
  input  logic                cfgLsbFirst,
  input  logic [LEN_W-1:0]    cfgWordLen,
  input  logic                cfgMosiEn,
  input  logic                cfgMisoEn,
  input  logic                cfgCsEn,
  output logic                wordValid,
  output logic                mosiValid,
  output logic                misoValid,
  output logic [MAX_WORD-1:0] mosiWord,
  output logic [MAX_WORD-1:0] misoWord,
  output logic                frameWarn,
  output logic                csEvent,
  output logic                csOld,
  output logic                csNew,
  output logic                xferStart,
  output logic                xferEnd,
  output logic [CNT_W-1:0]    xferWords
);
  logic [3:0]       pinsS;
  monCfg_t          cfgIn;
  monStrobe_t       stb;
  logic [IDX_W-1:0] bitPos;
  logic [1:0]       chanEn;

  assign cfgIn = '{cpol: cfgCpol, cpha: cfgCpha, csHigh: cfgCsActiveHigh,
                   lsbFirst: cfgLsbFirst, mosiEn: cfgMosiEn,
                   misoEn: cfgMisoEn, csEn: cfgCsEn};

  // order {sck, cs, mosi, miso}; clock and select start high
  spi_mon_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) sync_i (
    .clk(clk), .rstN(rstN), .din({sckIn, csIn, mosiIn, misoIn}), .dout(pinsS));

  spi_mon_ctrl #(.MAX_WORD(MAX_WORD), .DEF_LEN(DEF_LEN), .LEN_W(LEN_W),
                 .IDX_W(IDX_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .sckS(pinsS[3]), .csS(pinsS[2]),
    .cfgWrite(cfgWrite), .cfgIn(cfgIn), .cfgLen(cfgWordLen),
    .stb(stb), .bitPos(bitPos), .chanEn(chanEn), .frameWarn(frameWarn),
    .csEvent(csEvent), .csOld(csOld), .csNew(csNew),
    .xferStart(xferStart), .xferEnd(xferEnd), .xferWords(xferWords));

  spi_mon_datapath #(.MAX_WORD(MAX_WORD), .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .bitPos(bitPos), .chanEn(chanEn),
    .mosiBit(pinsS[1]), .misoBit(pinsS[0]), .wordValid(wordValid),
    .mosiValid(mosiValid), .misoValid(misoValid),
    .mosiWord(mosiWord), .misoWord(misoWord));
endmodule

// File: rtl/spi_mon_checker.sv
module spi_mon_checker (
  input logic clk,
  input logic rstN,
  input logic wordValid,
  input logic mosiValid,
  input logic misoValid,
  input logic frameWarn,
  input logic csEvent,
  input logic csOld,
  input logic csNew,
  input logic xferStart,
  input logic xferEnd
);
  a_r10_mosi_valid_in_word: assert property (@(posedge clk) disable iff (!rstN)
    mosiValid |-> wordValid);
  a_r10_miso_valid_in_word: assert property (@(posedge clk) disable iff (!rstN)
    misoValid |-> wordValid);
  a_r4_some_line_valid: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> (mosiValid || misoValid));
  a_r4_word_spacing: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);
  a_r9_warn_with_word: assert property (@(posedge clk) disable iff (!rstN)
    frameWarn |-> wordValid);
  a_r8_start_end_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({xferStart, xferEnd}));
  a_r8_mark_has_event: assert property (@(posedge clk) disable iff (!rstN)
    (xferStart || xferEnd) |-> csEvent);
  a_r8_event_is_change: assert property (@(posedge clk) disable iff (!rstN)
    csEvent |-> (csOld != csNew));
endmodule

bind spi_bus_monitor spi_mon_checker chk_i (
  .clk(clk), .rstN(rstN), .wordValid(wordValid), .mosiValid(mosiValid),
  .misoValid(misoValid), .frameWarn(frameWarn), .csEvent(csEvent),
  .csOld(csOld), .csNew(csNew), .xferStart(xferStart), .xferEnd(xferEnd));

// File: tb/spi_bus_monitor_tb_top.sv
`timescale 1ns/1ps
module spi_bus_monitor_tb_top;
  localparam int MAXW = 32;
  localparam int LW = 6;
  localparam int HP = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic sckIn = 1'b0, mosiIn = 1'b0, misoIn = 1'b0, csIn = 1'b1;
  logic cfgWrite = 1'b0, cfgCpol = 1'b0, cfgCpha = 1'b0, cfgCsActiveHigh = 1'b0;
  logic cfgLsbFirst = 1'b0, cfgMosiEn = 1'b1, cfgMisoEn = 1'b1, cfgCsEn = 1'b1;
  logic [LW-1:0] cfgWordLen = 6'd8;
  logic wordValid, mosiValid, misoValid, frameWarn, csEvent, csOld, csNew;
  logic xferStart, xferEnd;
  logic [MAXW-1:0] mosiWord, misoWord;
  logic [15:0] xferWords;

  always #2 clk = ~clk;

  spi_bus_monitor dut_i (.*);

  int nRun = 0, nFail = 0;
  bit doneFlag = 0;
  // bench mirror of the configuration
  bit bCpol = 0, bCpha = 0, bCsHigh = 0, bLsb = 0, bMosiEn = 1, bMisoEn = 1;
  int bLen = 8;
  // monitor state
  int nGot = 0, nStart = 0, nEnd = 0, nCsEv = 0;
  logic [31:0] gotMosi [8], gotMiso [8];
  bit gotMosiV [8], gotMisoV [8], gotWarn [8];
  int lastXw = 0;
  logic [31:0] expMosi [8], expMiso [8];

  always @(negedge clk) if (rstN && !doneFlag) begin
    if (wordValid && nGot < 8) begin
      gotMosi[nGot] = mosiWord; gotMiso[nGot] = misoWord;
      gotMosiV[nGot] = mosiValid; gotMisoV[nGot] = misoValid;
      gotWarn[nGot] = frameWarn; nGot++;
    end
    if (xferStart) nStart++;
    if (xferEnd) begin nEnd++; lastXw = xferWords; end
    if (csEvent) nCsEv++;
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] maskLen(logic [31:0] w, int len);
    logic [63:0] m = (64'd1 << len) - 64'd1;
    return w & m[31:0];
  endfunction

  function automatic logic csOn();
    return bCsHigh ? 1'b1 : 1'b0;
  endfunction

  task automatic idleCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clrMon();
    nGot = 0; nStart = 0; nEnd = 0; nCsEv = 0; lastXw = -1;
  endtask

  task automatic applyCfg(bit cp, bit ph, bit csh, bit lsb, int len, bit me, bit se,
                          bit csen, bit taken);
    @(negedge clk);
    cfgCpol = cp; cfgCpha = ph; cfgCsActiveHigh = csh; cfgLsbFirst = lsb;
    cfgWordLen = LW'(len); cfgMosiEn = me; cfgMisoEn = se; cfgCsEn = csen;
    cfgWrite = 1'b1;
    @(negedge clk);
    cfgWrite = 1'b0;
    if (taken) begin
      bCpol = cp; bCpha = ph; bCsHigh = csh; bLsb = lsb; bLen = len;
      bMosiEn = me; bMisoEn = se;
    end
  endtask

  // drive nb bits of a word in the mirrored mode and bit order
  task automatic sendBits(logic [31:0] mw, logic [31:0] sw, int nb);
    for (int i = 0; i < nb; i++) begin
      int idx = bLsb ? i : bLen - 1 - i;
      if (!bCpha) begin
        mosiIn = mw[idx]; misoIn = sw[idx];
        idleCycles(HP); sckIn = ~sckIn;
        idleCycles(HP); sckIn = ~sckIn;
      end else begin
        sckIn = ~sckIn; mosiIn = mw[idx]; misoIn = sw[idx];
        idleCycles(HP); sckIn = ~sckIn;
        idleCycles(HP);
      end
    end
  endtask

  task automatic doXfer(int n);
    clrMon();
    csIn = csOn(); idleCycles(2 * HP);
    for (int w = 0; w < n; w++) sendBits(expMosi[w], expMiso[w], bLen);
    idleCycles(2 * HP);
    csIn = ~csOn(); idleCycles(10);
  endtask

  task automatic verifyXfer(string req, int n);
    check(nGot == n, req, "word count", nGot, n);
    for (int w = 0; w < n && w < nGot; w++) begin
      logic [31:0] em = bMosiEn ? maskLen(expMosi[w], bLen) : 32'd0;
      logic [31:0] es = bMisoEn ? maskLen(expMiso[w], bLen) : 32'd0;
      check(gotMosi[w] == em, req, "mosi word", gotMosi[w], em);
      check(gotMiso[w] == es, req, "miso word", gotMiso[w], es);
      check(gotMosiV[w] == bMosiEn && gotMisoV[w] == bMisoEn, req, "line valids",
            {gotMosiV[w], gotMisoV[w]}, {bMosiEn, bMisoEn});
      check(!gotWarn[w], req, "no warning", gotWarn[w], 0);
    end
    check(nStart == 1 && nEnd == 1 && nCsEv == 2, "R8", "start/end/events",
          {nStart[3:0], nEnd[3:0], nCsEv[3:0]}, 12'h112);
    check(lastXw == n, "R8", "xferWords", lastXw, n);
  endtask

  task automatic setIdle();
    @(negedge clk); sckIn = bCpol; csIn = ~csOn(); idleCycles(10);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!wordValid && !mosiValid && !misoValid && !frameWarn && !csEvent &&
          !xferStart && !xferEnd && mosiWord == 0 && misoWord == 0 && xferWords == 0,
          "R1", "reset outputs", {wordValid, csEvent, frameWarn}, 0);
    idleCycles(6);

    // R1 defaults: mode (0,0), MSB first, 8 bits, active-low select
    expMosi[0] = 32'hA5; expMiso[0] = 32'h3C;
    doXfer(1); verifyXfer("R1", 1);

    // R2 every mode
    for (int m = 0; m < 4; m++) begin
      applyCfg(m[1], m[0], 0, 0, 8, 1, 1, 1, 1); setIdle();
      expMosi[0] = 32'h96 ^ m; expMiso[0] = 32'h69 + m; expMosi[1] = 32'h01; expMiso[1] = 32'h80;
      doXfer(2); verifyXfer("R2", 2);
    end

    // R3 LSB first, 12 bits
    applyCfg(0, 0, 0, 1, 12, 1, 1, 1, 1); setIdle();
    expMosi[0] = 32'h5A3; expMiso[0] = 32'h0F1;
    doXfer(1); verifyXfer("R3", 1);

    // R4 extremes of length and rejected writes
    applyCfg(0, 0, 0, 0, 1, 1, 1, 1, 1); setIdle();
    expMosi[0] = 1; expMiso[0] = 0; expMosi[1] = 0; expMiso[1] = 1; expMosi[2] = 1; expMiso[2] = 1;
    doXfer(3); verifyXfer("R4", 3);
    applyCfg(0, 0, 0, 0, 32, 1, 1, 1, 1); setIdle();
    expMosi[0] = 32'hDEADBEEF; expMiso[0] = 32'h80000001;
    doXfer(1); verifyXfer("R4", 1);
    applyCfg(0, 0, 0, 0, 0, 1, 1, 1, 0);
    applyCfg(0, 0, 0, 0, 33, 1, 1, 1, 0);
    applyCfg(0, 0, 0, 0, 8, 0, 0, 1, 0);
    setIdle();
    expMosi[0] = 32'h12345678; expMiso[0] = 32'hCAFEF00D;
    doXfer(1); verifyXfer("R4", 1);

    // R5 active-high select
    applyCfg(0, 0, 1, 0, 8, 1, 1, 1, 1); setIdle();
    expMosi[0] = 32'hC3; expMiso[0] = 32'h5A;
    doXfer(1); verifyXfer("R5", 1);
    check(csOld == 1'b1 && csNew == 1'b0, "R8", "old/new on end", {csOld, csNew}, 2'b10);
    applyCfg(0, 0, 0, 0, 8, 1, 1, 1, 1); setIdle();

    // R6 partial word dropped on select change
    clrMon();
    csIn = 1'b0; idleCycles(2 * HP);
    sendBits(32'hFF, 32'hFF, 3);
    csIn = 1'b1; idleCycles(10);
    check(nGot == 0 && lastXw == 0, "R6", "partial word dropped", nGot, 0);
    expMosi[0] = 32'h3E; expMiso[0] = 32'h81;
    doXfer(1); verifyXfer("R6", 1);

    // R7 clock edges with select deasserted
    clrMon();
    sendBits(32'hAA, 32'h55, 8);
    idleCycles(10);
    check(nGot == 0 && nCsEv == 0, "R7", "edges ignored when deselected", nGot, 0);
    expMosi[0] = 32'h77; expMiso[0] = 32'h11;
    doXfer(1); verifyXfer("R7", 1);

    // R10 absent slave-to-master line
    applyCfg(0, 0, 0, 0, 8, 1, 0, 1, 1); setIdle();
    expMosi[0] = 32'h9C; expMiso[0] = 32'hFF;
    doXfer(1); verifyXfer("R10", 1);
    applyCfg(0, 0, 0, 0, 8, 1, 1, 1, 1); setIdle();

    // R11 write during a transfer is ignored
    clrMon();
    csIn = 1'b0; idleCycles(2 * HP);
    applyCfg(0, 0, 0, 1, 4, 1, 1, 1, 0);
    expMosi[0] = 32'hB4; expMiso[0] = 32'h2D;
    sendBits(expMosi[0], expMiso[0], 8);
    idleCycles(2 * HP); csIn = 1'b1; idleCycles(10);
    check(nGot == 1 && gotMosi[0] == 32'hB4 && gotMiso[0] == 32'h2D, "R11",
          "config held during transfer", gotMosi[0], 32'hB4);

    // R13 and R9: framing off
    applyCfg(0, 0, 0, 0, 8, 1, 1, 0, 1); setIdle();
    clrMon();
    sendBits(32'h5C, 32'hA3, 8); idleCycles(10);
    check(nGot == 1 && gotMosi[0] == 32'h5C, "R13", "edges taken without framing", gotMosi[0], 32'h5C);
    check(nGot == 1 && gotWarn[0], "R9", "warning on deselected start", gotWarn[0], 1);
    clrMon();
    csIn = 1'b0; idleCycles(10);
    sendBits(32'h0D, 32'hD0, 8); idleCycles(10);
    check(nGot == 1 && !gotWarn[0], "R9", "no warning when selected", gotWarn[0], 0);
    check(nCsEv == 0 && nStart == 0, "R13", "no select events", nCsEv, 0);
    csIn = 1'b1; idleCycles(4);
    applyCfg(0, 0, 0, 0, 8, 1, 1, 1, 1); setIdle();

    // R12 latency with one-bit words
    applyCfg(0, 0, 0, 0, 1, 1, 1, 1, 1); setIdle();
    csIn = 1'b0; mosiIn = 1'b1; idleCycles(10);
    sckIn = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(!wordValid, "R12", "not before third edge", wordValid, 0);
    @(posedge clk); @(negedge clk);
    check(wordValid && mosiWord == 1, "R12", "word after third edge", wordValid, 1);
    sckIn = 1'b0; idleCycles(4);
    csIn = 1'b1; idleCycles(10);

    // random configurations and data
    for (int it = 0; it < 24; it++) begin
      int r = $urandom;
      int len = 1 + ($urandom % MAXW);
      int n = 1 + ($urandom % 3);
      bit me = r[4], se = r[5];
      if (!me && !se) me = 1;
      applyCfg(r[0], r[1], r[2], r[3], len, me, se, 1, 1); setIdle();
      for (int w = 0; w < n; w++) begin expMosi[w] = $urandom; expMiso[w] = $urandom; end
      doXfer(n); verifyXfer("R2", n);
    end

    doneFlag = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!doneFlag) begin
      doneFlag = 1;
      nRun++; nFail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule